// File: doc/BRIEF.md
# Level-Driven Weight Split Controller

This controller decides how a batch of weights is shared between a group of fast compute modules and a group of slow, low-energy compute modules. Software quantises the expected workload of the next time window into one of `N_LEVELS` levels. It can also ask for an extra turbo level, `N_LEVELS+1`, which is used to catch up after a misprediction. Each level owns one entry in a small table. The entry holds the largest number of weights the slow group can finish inside that level's per-task time budget. The table is filled during an initialisation phase, through a write port that is honoured only while the controller is idle.

For each request the controller first sets the slow share to the smaller of the table cap and the total weight count. The fast group receives the rest. Each share is then spread evenly over the modules of its group, and the controller builds the start offset of every module as a running sum over the whole placement: fast modules first, then slow modules. When the result is ready, the controller publishes all counts and offsets together with a one-cycle valid strobe, ready for a placement sequencer.

The design is a five-state machine:
- `ST_IDLE` waits for a request (transition *accept*).
- `ST_LOOKUP` reads the table and forms both shares (*shares-ready*).
- `ST_SPLIT` latches the per-module counts (*split-ready*).
- `ST_ACCUM` builds one offset per cycle. It loops on *next-module* and leaves on *last-module*.
- `ST_FINISH` publishes the result and returns to idle (*publish*).

Top module: `wsplit_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every count, offset and `act_level` output reads 0. All table entries are 0.
- R2: The first request accepted after reset uses the entry of level `N_LEVELS` (4 by default) whatever `req_level` says, and reports 4 on `act_level`.
- R3: The slow share equals the smaller of the selected table cap and `req_total`. The fast share equals `req_total` minus the slow share.
- R4: A share of S over M modules gives every module floor(S/M) weights. The modules with index below S mod M each take one more, so the counts are non-increasing with index, differ by at most one, and add up to S. Module k's count sits at bits [16k+15:16k] of its group bus.
- R5: Offsets are prefix sums in the order fast module 0..3, then slow module 0..3. Fast module 0 starts at 0, and slow module 0 starts at the fast share.
- R6: `done` is high for exactly one cycle. It is first seen high after the eleventh rising edge (`FAST_MODS+SLOW_MODS+3`) that follows the edge that accepted the request. `busy` is high from the accepting edge until `ST_FINISH` ends.
- R7: While `busy` is high, requests and table writes are ignored: no extra result appears and the table keeps its old value.
- R8: Level code 5 (`N_LEVELS+1`) selects the turbo entry. Codes 0 and 6..7 are treated as turbo as well. Table writes address level codes 1..5.
- R9: When the selected cap is at least `req_total`, the whole batch goes to the slow group and every fast count is 0.
- R10: Count, offset and `act_level` outputs change only on the edge that raises `done`, and hold their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe (idle only) |
| cfg_level | input | 3 | Level code of the entry to write (1..5) |
| cfg_slow_cap | input | 16 | Slow-group weight cap for that level |
| req | input | 1 | Split request |
| req_level | input | 3 | Requested level code |
| req_total | input | 16 | Total weight count to place |
| busy | output | 1 | Controller is working on a request |
| done | output | 1 | One-cycle strobe: new result published |
| act_level | output | 3 | Level code actually used for the published result |
| fast_cnt | output | 64 | Per-module counts, fast group, 16 bits each |
| fast_off | output | 64 | Per-module start offsets, fast group |
| slow_cnt | output | 64 | Per-module counts, slow group |
| slow_off | output | 64 | Per-module start offsets, slow group |

## Verification
The hardest situation to create from the ports is a request and a table write that both land in the middle of the offset-accumulation loop. Both must leave no trace: no extra result, and no change to the entry that is read next. The stimulus starts a split, waits a few cycles until the machine is inside `ST_ACCUM`, and then drives a conflicting request together with a write to the same level's entry. It then checks that exactly one result appears and that it matches the old cap. A second request to that level shows that the table was not changed. A write made afterwards while idle does take effect, which separates "ignored" from "broken".

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SPLIT,
        ST_ACCUM,
        ST_FINISH
    } wsplit_state_e;

endpackage

// File: rtl/wsplit_table.sv
// Level-indexed table of slow-group weight caps. Entry e serves level code e+1.
module wsplit_table #(
    parameter int ENTRIES = 5,
    parameter int LVL_W   = 3,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [CNT_W-1:0] wr_cap,
    input  logic [LVL_W-1:0] rd_lvl,
    output logic [CNT_W-1:0] rd_cap
);

    logic [CNT_W-1:0] cap_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                cap_q[e] <= '0;
            end
        end else if (wr_en) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_lvl == LVL_W'(e + 1)) begin
                    cap_q[e] <= wr_cap;
                end
            end
        end
    end

    always_comb begin
        rd_cap = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (rd_lvl == LVL_W'(e + 1)) begin
                rd_cap = cap_q[e];
            end
        end
    end

endmodule

// File: rtl/wsplit_even.sv
// Spreads a share over MODS modules; lower indices absorb the remainder.
module wsplit_even #(
    parameter int MODS  = 4,
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]            share,
    output logic [MODS-1:0][CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] DIV = CNT_W'(MODS);

    logic [CNT_W-1:0] quo;
    logic [CNT_W-1:0] rem;

    assign quo = share / DIV;
    assign rem = share % DIV;

    for (genvar k = 0; k < MODS; k++) begin : g_mod
        localparam logic [CNT_W-1:0] KV = CNT_W'(k);
        assign cnt[k] = quo + {{(CNT_W-1){1'b0}}, (KV < rem)};
    end

endmodule

// File: rtl/wsplit_ctrl.sv
module wsplit_ctrl
    import wsplit_pkg::*;
#(
    parameter int N_LEVELS  = 4,
    parameter int FAST_MODS = 4,
    parameter int SLOW_MODS = 4,
    parameter int CNT_W     = 16,
    localparam int LVL_W    = $clog2(N_LEVELS + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [LVL_W-1:0]           cfg_level,
    input  logic [CNT_W-1:0]           cfg_slow_cap,
    input  logic                       req,
    input  logic [LVL_W-1:0]           req_level,
    input  logic [CNT_W-1:0]           req_total,
    output logic                       busy,
    output logic                       done,
    output logic [LVL_W-1:0]           act_level,
    output logic [FAST_MODS*CNT_W-1:0] fast_cnt,
    output logic [FAST_MODS*CNT_W-1:0] fast_off,
    output logic [SLOW_MODS*CNT_W-1:0] slow_cnt,
    output logic [SLOW_MODS*CNT_W-1:0] slow_off
);

    localparam int TOT     = FAST_MODS + SLOW_MODS;
    localparam int ENTRIES = N_LEVELS + 1;
    localparam int CUR_W   = (TOT > 1) ? $clog2(TOT) : 1;
    localparam logic [CUR_W-1:0] CUR_LAST  = CUR_W'(TOT - 1);
    localparam logic [LVL_W-1:0] LVL_TOP   = LVL_W'(N_LEVELS);
    localparam logic [LVL_W-1:0] LVL_TURBO = LVL_W'(N_LEVELS + 1);

    wsplit_state_e state_q, state_d;

    logic                      first_q;
    logic [LVL_W-1:0]          lvl_q;
    logic [CNT_W-1:0]          total_q;
    logic [CNT_W-1:0]          slow_share_q;
    logic [CNT_W-1:0]          fast_share_q;
    logic [TOT-1:0][CNT_W-1:0] cnt_all_q;
    logic [TOT-1:0][CNT_W-1:0] off_all_q;
    logic [CUR_W-1:0]          cur_q;
    logic [CNT_W-1:0]          run_q;
    logic [TOT-1:0][CNT_W-1:0] pub_cnt_q;
    logic [TOT-1:0][CNT_W-1:0] pub_off_q;
    logic [LVL_W-1:0]          pub_lvl_q;
    logic                      done_q;

    logic [LVL_W-1:0]                lvl_pick;
    logic [CNT_W-1:0]                cap_rd;
    logic [CNT_W-1:0]                slow_pick;
    logic [FAST_MODS-1:0][CNT_W-1:0] fast_split;
    logic [SLOW_MODS-1:0][CNT_W-1:0] slow_split;

    // Level selection: first request after reset uses the top normal level,
    // codes outside 1..N_LEVELS+1 fall back to turbo.
    always_comb begin
        if (first_q) begin
            lvl_pick = LVL_TOP;
        end else if (req_level == '0 || req_level > LVL_TURBO) begin
            lvl_pick = LVL_TURBO;
        end else begin
            lvl_pick = req_level;
        end
    end

    wsplit_table #(
        .ENTRIES (ENTRIES),
        .LVL_W   (LVL_W),
        .CNT_W   (CNT_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we && (state_q == ST_IDLE)),
        .wr_lvl (cfg_level),
        .wr_cap (cfg_slow_cap),
        .rd_lvl (lvl_q),
        .rd_cap (cap_rd)
    );

    assign slow_pick = (cap_rd < total_q) ? cap_rd : total_q;

    wsplit_even #(
        .MODS  (FAST_MODS),
        .CNT_W (CNT_W)
    ) u_even_fast (
        .share (fast_share_q),
        .cnt   (fast_split)
    );

    wsplit_even #(
        .MODS  (SLOW_MODS),
        .CNT_W (CNT_W)
    ) u_even_slow (
        .share (slow_share_q),
        .cnt   (slow_split)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: accept, shares-ready, split-ready, next/last-module, publish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_SPLIT;
            ST_SPLIT:  state_d = ST_ACCUM;
            ST_ACCUM:  if (cur_q == CUR_LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath and published outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q      <= 1'b1;
            lvl_q        <= '0;
            total_q      <= '0;
            slow_share_q <= '0;
            fast_share_q <= '0;
            cnt_all_q    <= '0;
            off_all_q    <= '0;
            cur_q        <= '0;
            run_q        <= '0;
            pub_cnt_q    <= '0;
            pub_off_q    <= '0;
            pub_lvl_q    <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        lvl_q   <= lvl_pick;
                        total_q <= req_total;
                        first_q <= 1'b0;
                    end
                end
                ST_LOOKUP: begin
                    slow_share_q <= slow_pick;
                    fast_share_q <= total_q - slow_pick;
                end
                ST_SPLIT: begin
                    cnt_all_q[FAST_MODS-1:0]   <= fast_split;
                    cnt_all_q[TOT-1:FAST_MODS] <= slow_split;
                    cur_q <= '0;
                    run_q <= '0;
                end
                ST_ACCUM: begin
                    off_all_q[cur_q] <= run_q;
                    run_q            <= run_q + cnt_all_q[cur_q];
                    cur_q            <= cur_q + 1'b1;
                end
                ST_FINISH: begin
                    pub_cnt_q <= cnt_all_q;
                    pub_off_q <= off_all_q;
                    pub_lvl_q <= lvl_q;
                    done_q    <= 1'b1;
                end
                default: begin
                    done_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign act_level = pub_lvl_q;
    assign fast_cnt  = pub_cnt_q[FAST_MODS-1:0];
    assign slow_cnt  = pub_cnt_q[TOT-1:FAST_MODS];
    assign fast_off  = pub_off_q[FAST_MODS-1:0];
    assign slow_off  = pub_off_q[TOT-1:FAST_MODS];

endmodule

// File: rtl/wsplit_ctrl_chk.sv
module wsplit_ctrl_chk #(
    parameter int N_LEVELS  = 4,
    parameter int FAST_MODS = 4,
    parameter int SLOW_MODS = 4,
    parameter int CNT_W     = 16,
    localparam int LVL_W    = $clog2(N_LEVELS + 2)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req,
    input logic                       busy,
    input logic                       done,
    input logic [LVL_W-1:0]           act_level,
    input logic [FAST_MODS*CNT_W-1:0] fast_cnt,
    input logic [FAST_MODS*CNT_W-1:0] fast_off,
    input logic [SLOW_MODS*CNT_W-1:0] slow_cnt,
    input logic [SLOW_MODS*CNT_W-1:0] slow_off
);

    localparam int TOT = FAST_MODS + SLOW_MODS;

    logic [TOT-1:0][CNT_W-1:0] c_all;
    logic [TOT-1:0][CNT_W-1:0] o_all;
    assign c_all = {slow_cnt, fast_cnt};
    assign o_all = {slow_off, fast_off};

    // Cycles elapsed since the accepting edge
    logic [7:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (req && !busy) begin
            lat_q <= '0;
        end else if (lat_q != 8'hFF) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 8'(TOT + 3)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({act_level, fast_cnt, fast_off, slow_cnt, slow_off}));

    // R8
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act_level >= LVL_W'(1) && act_level <= LVL_W'(N_LEVELS + 1)));

    // R5
    off_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (o_all[0] == '0));

    for (genvar k = 0; k < TOT - 1; k++) begin : g_chain
        // R5
        off_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> (o_all[k+1] == CNT_W'(o_all[k] + c_all[k])));
    end

    for (genvar k = 0; k < TOT - 1; k++) begin : g_even
        if (k != FAST_MODS - 1) begin : g_same_group
            // R4
            even_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> ((c_all[k] == c_all[k+1]) ||
                          ({1'b0, c_all[k]} == {1'b0, c_all[k+1]} + 1'b1)));
        end
    end

endmodule

bind wsplit_ctrl wsplit_ctrl_chk #(
    .N_LEVELS  (N_LEVELS),
    .FAST_MODS (FAST_MODS),
    .SLOW_MODS (SLOW_MODS),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/wsplit_ctrl_bench.sv
module wsplit_ctrl_bench;

    localparam int LAT = 12;   // negedge stamp to done sample: 11 edges after the accepting edge

    typedef struct packed {
        logic [2:0]  lvl;
        logic [63:0] fc;
        logic [63:0] fo;
        logic [63:0] sc;
        logic [63:0] so;
        logic [31:0] stamp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_level = '0;
    logic [15:0] cfg_slow_cap = '0;
    logic        req = 1'b0;
    logic [2:0]  req_level = '0;
    logic [15:0] req_total = '0;
    logic        busy, done;
    logic [2:0]  act_level;
    logic [63:0] fast_cnt, fast_off, slow_cnt, slow_off;

    int   vectors = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    bit   first = 1'b1;
    int   mtbl [6];
    exp_t sb [$];
    exp_t mon_e;
    exp_t last_e;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wsplit_ctrl u_wsplit_ctrl (
        .clk, .rst_n, .cfg_we, .cfg_level, .cfg_slow_cap,
        .req, .req_level, .req_total,
        .busy, .done, .act_level,
        .fast_cnt, .fast_off, .slow_cnt, .slow_off
    );

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic exp_t model(int lvl, int total);
        exp_t e;
        int   slow, fast, run;
        e = '0;
        slow = (mtbl[lvl] < total) ? mtbl[lvl] : total;
        fast = total - slow;
        e.lvl = lvl[2:0];
        run = 0;
        for (int k = 0; k < 4; k++) begin
            int c = fast / 4 + ((k < fast % 4) ? 1 : 0);
            e.fc[k*16 +: 16] = c[15:0];
            e.fo[k*16 +: 16] = run[15:0];
            run += c;
        end
        for (int k = 0; k < 4; k++) begin
            int c = slow / 4 + ((k < slow % 4) ? 1 : 0);
            e.sc[k*16 +: 16] = c[15:0];
            e.so[k*16 +: 16] = run[15:0];
            run += c;
        end
        return e;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R7", "unexpected result level", {61'b0, act_level}, 64'hFFFF);
            end else begin
                mon_e = sb.pop_front();
                check("R2,R8", "act_level", {61'b0, act_level}, {61'b0, mon_e.lvl});
                check("R3,R4,R9", "fast_cnt", fast_cnt, mon_e.fc);
                check("R3,R4", "slow_cnt", slow_cnt, mon_e.sc);
                check("R5", "fast_off", fast_off, mon_e.fo);
                check("R5", "slow_off", slow_off, mon_e.so);
                check("R6", "latency", 64'(cyc - int'(mon_e.stamp)), 64'(LAT));
                last_e = mon_e;
            end
        end
    end

    task automatic cfg_write(int lvl, int cap);
        @(negedge clk);
        while (busy) @(negedge clk);
        #1;
        cfg_we = 1'b1; cfg_level = lvl[2:0]; cfg_slow_cap = cap[15:0];
        @(negedge clk);
        #1 cfg_we = 1'b0;
        mtbl[lvl] = cap;
    endtask

    task automatic issue(int lvl, int total, bit wait_done);
        exp_t e;
        int   eff;
        @(negedge clk);
        while (busy) @(negedge clk);
        eff = first ? 4 : ((lvl == 0 || lvl > 5) ? 5 : lvl);
        first = 1'b0;
        e = model(eff, total);
        e.stamp = cyc;
        sb.push_back(e);
        #1;
        req = 1'b1; req_level = lvl[2:0]; req_total = total[15:0];
        @(negedge clk);
        #1 req = 1'b0;
        if (wait_done) begin
            while (sb.size() != 0) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) mtbl[i] = 0;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy/done", {62'b0, busy, done}, 64'h0);
        check("R1", "fast_cnt", fast_cnt, 64'h0);
        check("R1", "slow_cnt", slow_cnt, 64'h0);
        check("R1", "offsets", fast_off | slow_off, 64'h0);
        check("R1", "act_level", {61'b0, act_level}, 64'h0);

        cfg_write(1, 1000);
        cfg_write(2, 500);
        cfg_write(3, 250);
        cfg_write(4, 100);
        cfg_write(5, 0);

        issue(1, 400, 1'b1);    // R2: first request runs at level 4
        issue(1, 1000, 1'b1);   // R9: all to slow group
        issue(2, 1003, 1'b1);   // R4: uneven fast share
        issue(3, 7, 1'b1);      // R4, R9: small share with remainder
        issue(5, 1000, 1'b1);   // R8: turbo entry
        issue(0, 9, 1'b1);      // R8: code 0 maps to turbo
        issue(7, 6, 1'b1);      // R8: out-of-range code maps to turbo
        issue(2, 0, 1'b1);      // R3: empty batch

        // R7: request and table write during busy are ignored
        issue(1, 50, 1'b0);
        repeat (3) @(negedge clk);
        // R10: outputs hold while a new split is in progress
        check("R10", "fast_cnt during busy", fast_cnt, last_e.fc);
        #1;
        req = 1'b1; req_level = 3'd3; req_total = 16'd999;
        cfg_we = 1'b1; cfg_level = 3'd1; cfg_slow_cap = 16'd3;
        @(negedge clk);
        #1;
        req = 1'b0; cfg_we = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (15) @(negedge clk);
        issue(1, 50, 1'b1);     // R7: cap still 1000
        cfg_write(1, 3);        // idle write takes effect
        issue(1, 50, 1'b1);

        repeat (20) @(negedge clk);
        // R10: results held long after done
        check("R10", "fast_cnt hold", fast_cnt, last_e.fc);
        check("R10", "slow_off hold", slow_off, last_e.so);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule